// File: doc/BRIEF.md
# Invalidate Forwarding Buffer

This block is the snoop-side helper of a cache that keeps no coherence state of its own and sits below the top of a single-processor memory hierarchy. When such a cache sees an invalidating command on the bus beneath it, it cannot act on the line itself. Instead it records the address and size in a bounded first-in first-out queue, and each entry is later sent upward as an Invalidate command to the levels above.

A registered service request tells the cache controller that forwarded invalidates are waiting. A registered blocked flag tells the bus side to stop snooping while the queue has no room. The consumer drains entries through a valid/ready pop port. Beside the queue, the block supplies the small combinational rules such a cache needs for misses: the bus command to issue, the line state to install on fill, and a warning when a hardware prefetch targets a line that is already valid.

Top module: `inval_fwd_buf`

## Requirements
- R1: An entry is queued only on a cycle with `snoop_valid` high, `is_top_level` low and `snoop_cmd` equal to one of the invalidating codes: ReadEx=2, Upgrade=3, Invalidate=4, WriteInvalidate=5. Read=0, Write=1, Writeback=6, SoftPrefetch=7 and HardPrefetch=8 never queue.
- R2: Entries leave in arrival order. The oldest entry is shown on `fwd_addr`/`fwd_size` with `fwd_valid` high from the cycle after its capture. `fwd_cmd` is always Invalidate (4). An entry is removed on a clock edge where `fwd_valid` and `fwd_ready` are both high.
- R3: `service_req` is a registered flag. It is high exactly while at least one entry is pending, and it falls on the edge where the last entry is popped.
- R4: `blocked` rises on the edge where an allocation brings the queue to DEPTH (default 50) entries. It falls on the edge of a pop taken from a full queue.
- R5: A capture and a pop on the same edge are both honoured and leave the entry count unchanged. This holds when the queue is full.
- R6: A capture attempted on a full queue without a pop on that edge is dropped. The queue contents stay unchanged and `overflow_err` is high for the following cycle only.
- R7: For every snoop, `snoop_next_state` equals `snoop_line_state`, and `snoop_supply` stays low.
- R8: `miss_bus_cmd` is Writeback (6) when `miss_cmd` is Writeback. It is Read (0) for every other command.
- R9: `fill_state` has bit 0 (valid) and bit 1 (writable) set and bit 2 (dirty) clear. Bit 3 (hardware-prefetched) is set only when `miss_cmd` is HardPrefetch (8).
- R10: `pf_warn` is high exactly when `miss_cmd` is HardPrefetch and bit 0 of `miss_line_state` is set.
- R11: While reset is asserted and after its release, `fwd_valid`, `service_req`, `blocked` and `overflow_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| is_top_level | input | 1 | This cache is the highest level; suppresses capture |
| snoop_valid | input | 1 | A snooped bus command is present |
| snoop_cmd | input | 4 | Snooped command code |
| snoop_addr | input | ADDR_W | Snooped address |
| snoop_size | input | SIZE_W | Snooped transfer size |
| snoop_line_state | input | 4 | Current state bits of the snooped line |
| snoop_next_state | output | 4 | State to keep for the snooped line |
| snoop_supply | output | 1 | Local data supply request (never raised) |
| miss_cmd | input | 4 | Command of the request that missed |
| miss_line_state | input | 4 | State bits of the addressed line |
| miss_bus_cmd | output | 4 | Bus command to issue for the miss |
| fill_state | output | 4 | State bits to install on fill |
| pf_warn | output | 1 | Hardware prefetch to an already valid line |
| fwd_valid | output | 1 | An invalidate is waiting to go upward |
| fwd_ready | input | 1 | Consumer takes the head entry |
| fwd_cmd | output | 4 | Forwarded command (Invalidate) |
| fwd_addr | output | ADDR_W | Address of the head entry |
| fwd_size | output | SIZE_W | Size of the head entry |
| service_req | output | 1 | Entries pending |
| blocked | output | 1 | Queue full |
| overflow_err | output | 1 | A capture was dropped on the previous edge |

## Verification
The queue is driven with a random mix of all nine command codes and an occasional top-level cycle. This separates the invalidating codes from the rest and shows that the top-level flag masks capture. Random phases alternate between a rarely-ready consumer, which pushes the queue into the full region, and an eager consumer, which keeps it near empty, so the fill and drain edges of `blocked` and `service_req` are both reached. Directed sequences fill the queue to exactly its depth, attempt an extra capture with and without a same-edge pop, and then drain it completely. These runs tell a dropped capture apart from an accepted one and expose any reordering of entries. The miss and snoop rules are checked every cycle against random line states, and the hardware-prefetch code is mixed in so the warning and fill-flag cases appear.

// File: rtl/ifb_pkg.sv
package ifb_pkg;
  localparam int CMD_W = 4;
  localparam int ST_W  = 4;

  localparam logic [CMD_W-1:0] C_READ      = 4'd0;
  localparam logic [CMD_W-1:0] C_WRITE     = 4'd1;
  localparam logic [CMD_W-1:0] C_READEX    = 4'd2;
  localparam logic [CMD_W-1:0] C_UPGRADE   = 4'd3;
  localparam logic [CMD_W-1:0] C_INVAL     = 4'd4;
  localparam logic [CMD_W-1:0] C_WRINV     = 4'd5;
  localparam logic [CMD_W-1:0] C_WRITEBACK = 4'd6;
  localparam logic [CMD_W-1:0] C_SWPF      = 4'd7;
  localparam logic [CMD_W-1:0] C_HWPF      = 4'd8;

  // line state bit positions
  localparam int SB_VALID = 0;
  localparam int SB_WR    = 1;
  localparam int SB_DIRTY = 2;
  localparam int SB_HWPF  = 3;

  function automatic logic is_invalidating(input logic [CMD_W-1:0] c);
    return (c == C_READEX) || (c == C_UPGRADE) || (c == C_INVAL) || (c == C_WRINV);
  endfunction
endpackage

// File: rtl/ifb_fifo.sv
module ifb_fifo #(
  parameter int DEPTH = 50,
  parameter int W     = 36
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic                       pop,
  input  logic [W-1:0]               din,
  output logic [W-1:0]               dout,
  output logic                       not_empty,
  output logic [$clog2(DEPTH+1)-1:0] cnt_nxt,
  output logic                       drop
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH-1);
  localparam logic [CNT_W-1:0] FULLC = CNT_W'(DEPTH);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             full, pop_ok, push_ok;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    full    = (cnt_q == FULLC);
    pop_ok  = pop && (cnt_q != '0);
    push_ok = push && (!full || pop_ok);
    drop    = push && !push_ok;
    rd_d    = pop_ok  ? bump(rd_q) : rd_q;
    wr_d    = push_ok ? bump(wr_q) : wr_q;
    cnt_d   = cnt_q;
    case ({push_ok, pop_ok})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_q] <= din;
  end

  assign dout      = mem[rd_q];
  assign not_empty = (cnt_q != '0);
  assign cnt_nxt   = cnt_d;

  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULLC);
  // R6
  drop_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop |-> (cnt_q == FULLC));
  // R5
  push_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && pop_ok) |=> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/ifb_snoop_sel.sv
module ifb_snoop_sel
  import ifb_pkg::*;
(
  input  logic             snoop_valid,
  input  logic [CMD_W-1:0] snoop_cmd,
  input  logic             is_top_level,
  input  logic [ST_W-1:0]  line_state,
  output logic             alloc,
  output logic [ST_W-1:0]  next_state,
  output logic             supply
);
  always_comb begin
    alloc      = snoop_valid && !is_top_level && is_invalidating(snoop_cmd);
    next_state = line_state;
    supply     = 1'b0;
  end
endmodule

// File: rtl/ifb_miss_policy.sv
module ifb_miss_policy
  import ifb_pkg::*;
(
  input  logic [CMD_W-1:0] miss_cmd,
  input  logic [ST_W-1:0]  line_state,
  output logic [CMD_W-1:0] bus_cmd,
  output logic [ST_W-1:0]  fill_state,
  output logic             pf_warn
);
  logic is_hwpf;
  always_comb begin
    is_hwpf    = (miss_cmd == C_HWPF);
    bus_cmd    = (miss_cmd == C_WRITEBACK) ? C_WRITEBACK : C_READ;
    fill_state = '0;
    fill_state[SB_VALID] = 1'b1;
    fill_state[SB_WR]    = 1'b1;
    fill_state[SB_HWPF]  = is_hwpf;
    pf_warn    = is_hwpf && line_state[SB_VALID];
  end
endmodule

// File: rtl/inval_fwd_buf.sv
module inval_fwd_buf
  import ifb_pkg::*;
#(
  parameter int DEPTH  = 50,
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              is_top_level,
  input  logic              snoop_valid,
  input  logic [3:0]        snoop_cmd,
  input  logic [ADDR_W-1:0] snoop_addr,
  input  logic [SIZE_W-1:0] snoop_size,
  input  logic [3:0]        snoop_line_state,
  output logic [3:0]        snoop_next_state,
  output logic              snoop_supply,
  input  logic [3:0]        miss_cmd,
  input  logic [3:0]        miss_line_state,
  output logic [3:0]        miss_bus_cmd,
  output logic [3:0]        fill_state,
  output logic              pf_warn,
  output logic              fwd_valid,
  input  logic              fwd_ready,
  output logic [3:0]        fwd_cmd,
  output logic [ADDR_W-1:0] fwd_addr,
  output logic [SIZE_W-1:0] fwd_size,
  output logic              service_req,
  output logic              blocked,
  output logic              overflow_err
);
  localparam int ENT_W = ADDR_W + SIZE_W;
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam logic [CNT_W-1:0] FULLC = CNT_W'(DEPTH);

  logic             alloc, drop, pop;
  logic [ENT_W-1:0] head;
  logic [CNT_W-1:0] cnt_nxt;
  logic             svc_d, svc_q, blk_d, blk_q, ovf_d, ovf_q;

  ifb_snoop_sel u_sel (
    .snoop_valid (snoop_valid),
    .snoop_cmd   (snoop_cmd),
    .is_top_level(is_top_level),
    .line_state  (snoop_line_state),
    .alloc       (alloc),
    .next_state  (snoop_next_state),
    .supply      (snoop_supply)
  );

  ifb_miss_policy u_pol (
    .miss_cmd  (miss_cmd),
    .line_state(miss_line_state),
    .bus_cmd   (miss_bus_cmd),
    .fill_state(fill_state),
    .pf_warn   (pf_warn)
  );

  assign pop = fwd_valid && fwd_ready;

  ifb_fifo #(.DEPTH(DEPTH), .W(ENT_W)) u_q (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (alloc),
    .pop      (pop),
    .din      ({snoop_addr, snoop_size}),
    .dout     (head),
    .not_empty(fwd_valid),
    .cnt_nxt  (cnt_nxt),
    .drop     (drop)
  );

  always_comb begin
    svc_d = (cnt_nxt != '0);
    blk_d = (cnt_nxt == FULLC);
    ovf_d = drop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      svc_q <= 1'b0;
      blk_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      svc_q <= svc_d;
      blk_q <= blk_d;
      ovf_q <= ovf_d;
    end
  end

  assign fwd_cmd      = C_INVAL;
  assign fwd_addr     = head[ENT_W-1:SIZE_W];
  assign fwd_size     = head[SIZE_W-1:0];
  assign service_req  = svc_q;
  assign blocked      = blk_q;
  assign overflow_err = ovf_q;

  // R3
  svc_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    service_req == fwd_valid);
  // R4
  blk_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |-> fwd_valid);
  // R6
  ovf_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_err |-> blocked);
  // R1
  top_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_top_level && !fwd_valid) |=> !fwd_valid);
  // R8
  wb_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_cmd == C_WRITEBACK) |-> (miss_bus_cmd == C_WRITEBACK));
endmodule

// File: tb/sim_inval_fwd_buf.sv
module sim_inval_fwd_buf;
  localparam int DEPTH = 50;
  localparam int AW = 32;
  localparam int SW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic is_top_level = 1'b0, snoop_valid = 1'b0, fwd_ready = 1'b0;
  logic [3:0] snoop_cmd = '0, snoop_line_state = '0, miss_cmd = '0, miss_line_state = '0;
  logic [AW-1:0] snoop_addr = '0;
  logic [SW-1:0] snoop_size = '0;
  logic [3:0] snoop_next_state, miss_bus_cmd, fill_state, fwd_cmd;
  logic snoop_supply, pf_warn, fwd_valid, service_req, blocked, overflow_err;
  logic [AW-1:0] fwd_addr;
  logic [SW-1:0] fwd_size;

  int nvec = 0, nbad = 0;
  logic [AW+SW-1:0] mq[$];

  always #4 clk = ~clk;

  inval_fwd_buf #(.DEPTH(DEPTH), .ADDR_W(AW), .SIZE_W(SW)) u0 (.*);

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic is_inv(input logic [3:0] c);
    return c == 4'd2 || c == 4'd3 || c == 4'd4 || c == 4'd5;
  endfunction
  function automatic logic [3:0] exp_bus(input logic [3:0] c);
    return (c == 4'd6) ? 4'd6 : 4'd0;
  endfunction
  function automatic logic [3:0] exp_fill(input logic [3:0] c);
    return (c == 4'd8) ? 4'b1011 : 4'b0011;
  endfunction

  // one clock: inputs applied at negedge, comb checks, model update, registered checks
  task automatic step(input logic v, input logic [3:0] c, input logic [AW-1:0] a,
                      input logic [SW-1:0] s, input logic top, input logic rdy);
    logic pop_m, push_m, ovf_m;
    snoop_valid = v; snoop_cmd = c; snoop_addr = a; snoop_size = s;
    is_top_level = top; fwd_ready = rdy;
    miss_cmd = 4'($urandom % 9);
    miss_line_state = 4'($urandom);
    snoop_line_state = 4'($urandom);
    #1;
    chk(snoop_next_state == snoop_line_state, "R7 state kept", 64'(snoop_next_state), 64'(snoop_line_state));
    chk(snoop_supply == 1'b0, "R7 no supply", 64'(snoop_supply), 0);
    chk(miss_bus_cmd == exp_bus(miss_cmd), "R8 bus cmd", 64'(miss_bus_cmd), 64'(exp_bus(miss_cmd)));
    chk(fill_state == exp_fill(miss_cmd), "R9 fill state", 64'(fill_state), 64'(exp_fill(miss_cmd)));
    chk(pf_warn == (miss_cmd == 4'd8 && miss_line_state[0]), "R10 prefetch warn",
        64'(pf_warn), 64'(miss_cmd == 4'd8 && miss_line_state[0]));
    if (mq.size() != 0) begin
      chk(fwd_valid == 1'b1, "R2 head valid", 64'(fwd_valid), 1);
      chk({fwd_addr, fwd_size} == mq[0], "R2 head order", 64'({fwd_addr, fwd_size}), 64'(mq[0]));
      chk(fwd_cmd == 4'd4, "R2 fwd cmd", 64'(fwd_cmd), 4);
    end else begin
      chk(fwd_valid == 1'b0, "R2 empty", 64'(fwd_valid), 0);
    end
    // R1 capture rule, R5 same-edge pop and push
    pop_m  = (mq.size() != 0) && rdy;
    push_m = v && is_inv(c) && !top;
    ovf_m  = 1'b0;
    if (pop_m) void'(mq.pop_front());
    if (push_m) begin
      if (mq.size() < DEPTH) mq.push_back({a, s});
      else ovf_m = 1'b1;
    end
    @(posedge clk);
    @(negedge clk);
    chk(service_req == (mq.size() != 0), "R3 service", 64'(service_req), 64'(mq.size() != 0));
    chk(blocked == (mq.size() == DEPTH), "R4 blocked", 64'(blocked), 64'(mq.size() == DEPTH));
    chk(overflow_err == ovf_m, "R6 overflow", 64'(overflow_err), 64'(ovf_m));
  endtask

  bit done = 0;
  initial begin
    #(8 * 200000);
    if (!done) begin
      nvec++; nbad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1f0b));
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!fwd_valid && !service_req && !blocked && !overflow_err, "R11 in reset",
        64'({fwd_valid, service_req, blocked, overflow_err}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!fwd_valid && !service_req && !blocked && !overflow_err, "R11 after reset",
        64'({fwd_valid, service_req, blocked, overflow_err}), 0);

    // R1: top level and non-invalidating commands never queue
    step(1, 4'd4, 32'h100, 4'd3, 1, 0);
    step(1, 4'd0, 32'h104, 4'd3, 0, 0);
    step(1, 4'd6, 32'h108, 4'd3, 0, 0);
    step(0, 4'd2, 32'h10c, 4'd3, 0, 0);

    // fill to exactly DEPTH, check R4 rise
    for (int i = 0; i < DEPTH; i++) step(1, 4'(2 + i % 4), 32'h1000 + 32'(i), 4'(i), 0, 0);
    // R6: extra capture on full queue is dropped
    step(1, 4'd4, 32'hdead, 4'd1, 0, 0);
    step(0, 4'd0, 0, 0, 0, 0);
    // R5: capture with same-edge pop at full keeps count (blocked stays)
    step(1, 4'd3, 32'hbeef, 4'd2, 0, 1);
    chk(blocked == 1'b1, "R5 full kept", 64'(blocked), 1);
    // R4: pop from full clears blocked
    step(0, 4'd0, 0, 0, 0, 1);
    // drain to empty, R3 fall
    for (int i = 0; i < DEPTH + 2; i++) step(0, 4'd0, 0, 0, 0, 1);

    // random phases: slow consumer, then eager consumer
    for (int ph = 0; ph < 4; ph++) begin
      for (int i = 0; i < 700; i++) begin
        step($urandom % 4 != 0, 4'($urandom % 9), $urandom, 4'($urandom),
             ($urandom % 8) == 0, (ph % 2 == 0) ? (($urandom % 8) == 0) : (($urandom % 4) != 0));
      end
    end
    for (int i = 0; i < DEPTH + 2; i++) step(0, 4'd0, 0, 0, 0, 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule